// File: doc/BRIEF.md
# Slewing Delay Pointer Generator

This block holds the running delay of a sample delay line and steers it, one frame at a time, toward a requested delay. The request arrives as a single byte that sets the upper bits of the target; the lower bits of the target are zero. At each frame strobe the running delay moves by a small fixed step toward the target. It rises by four when it is short and falls by two when it is long. From the adjusted delay the block then forms the memory read pointer as the write pointer minus the delay. Because of this, a change of the requested delay makes the read position glide instead of jump.

The running delay is kept even, so left and right words stored in pairs stay aligned. Both outputs are registered. They change only on a clock edge at which the frame strobe is high, and keep their value between strobes.

Top module: `slew_delay_ptr`

## Requirements
- R1: A synchronous active-high reset sets the delay output and the read pointer output to zero.
- R2: When the frame strobe is low at a clock edge, both outputs keep their value whatever the request byte and the write pointer do.
- R3: The target is the request byte placed in the top 8 bits of a 16-bit word with the low 8 bits zero. The delay is compared with it as an unsigned 16-bit number, so a request of 0x80 or above counts as a large delay.
- R4: At a strobe where the delay equals the target, the delay is left unchanged.
- R5: At a strobe where the delay is above the target, the delay decreases by exactly 2.
- R6: At a strobe where the delay is below the target, the delay increases by exactly 4.
- R7: At every strobe the read pointer becomes the sampled write pointer minus the new delay, taken modulo 2^16. Both outputs show the new values from the clock edge that samples the strobe.
- R8: The delay is always even; bit 0 is cleared before each comparison. When an upward approach overshoots the target by 2, the next strobe brings the delay back down onto the target, after which it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | One-cycle frame strobe that triggers one slew step |
| want_hi_i | input | 8 | Requested delay, upper byte |
| wr_ptr_i | input | 16 | Current write pointer of the delay memory |
| delay_o | output | 16 | Running delay in samples |
| rd_ptr_o | output | 16 | Read pointer, write pointer minus delay |

## Verification
The running delay is the only state that carries from frame to frame. A wrong value there shows on delay_o in the cycle after the strobe that caused it, and on rd_ptr_o in that same cycle as a wrong distance from the sampled write pointer. A wrong step size or direction is seen after a single strobe. A wrong even/odd state or a broken settle after overshoot appears within two strobes near the target. A wrong comparison width only shows once the request byte has its top bit set, so the long climb to the largest target is driven all the way through.

// File: rtl/slewdly_pkg.sv
package slewdly_pkg;

    // relation of the running delay to the target
    typedef enum logic [1:0] {
        REL_EQ    = 2'd0,
        REL_ABOVE = 2'd1,
        REL_BELOW = 2'd2
    } rel_e;

    // registered state carried between frames
    typedef struct packed {
        logic [15:0] delay;
        logic [15:0] rd_ptr;
    } slew_state_t;

    localparam int DEF_PTR_W   = 16;
    localparam int DEF_HI_W    = 8;
    localparam int DEF_UP_STEP = 4;
    localparam int DEF_DN_STEP = 2;

endpackage

// File: rtl/slewdly_target.sv
module slewdly_target
    import slewdly_pkg::*;
#(
    parameter int PTR_W = DEF_PTR_W,
    parameter int HI_W  = DEF_HI_W
) (
    input  logic [HI_W-1:0]  want_hi,
    input  logic [PTR_W-1:0] cur_delay,
    output logic [PTR_W-1:0] even_delay,
    output rel_e             rel
);
    localparam int LO_W = PTR_W - HI_W;

    logic [PTR_W-1:0] target;

    generate
        if (LO_W > 0) begin : g_pad
            assign target = {want_hi, {LO_W{1'b0}}};
        end else begin : g_full
            assign target = want_hi[PTR_W-1:0];
        end
    endgenerate

    // clear bit 0 so stereo word pairs stay aligned
    assign even_delay = {cur_delay[PTR_W-1:1], 1'b0};

    always_comb begin
        if (even_delay == target) begin
            rel = REL_EQ;
        end else if (even_delay > target) begin
            rel = REL_ABOVE;
        end else begin
            rel = REL_BELOW;
        end
    end
endmodule

// File: rtl/slewdly_step.sv
module slewdly_step
    import slewdly_pkg::*;
#(
    parameter int PTR_W   = DEF_PTR_W,
    parameter int UP_STEP = DEF_UP_STEP,
    parameter int DN_STEP = DEF_DN_STEP
) (
    input  logic [PTR_W-1:0] even_delay,
    input  rel_e             rel,
    output logic [PTR_W-1:0] next_delay
);
    localparam logic [PTR_W-1:0] UP_V = PTR_W'(UP_STEP);
    localparam logic [PTR_W-1:0] DN_V = PTR_W'(DN_STEP);

    always_comb begin
        unique case (rel)
            REL_ABOVE: next_delay = even_delay - DN_V;
            REL_BELOW: next_delay = even_delay + UP_V;
            default:   next_delay = even_delay;
        endcase
    end
endmodule

// File: rtl/slewdly_rdptr.sv
module slewdly_rdptr #(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] delay,
    output logic [PTR_W-1:0] rd_ptr
);
    // modular difference, wraps naturally at 2^PTR_W
    assign rd_ptr = wr_ptr - delay;
endmodule

// File: rtl/slew_delay_ptr.sv
module slew_delay_ptr
    import slewdly_pkg::*;
#(
    parameter int PTR_W   = DEF_PTR_W,
    parameter int HI_W    = DEF_HI_W,
    parameter int UP_STEP = DEF_UP_STEP,
    parameter int DN_STEP = DEF_DN_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic [HI_W-1:0]  want_hi_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    output logic [PTR_W-1:0] delay_o,
    output logic [PTR_W-1:0] rd_ptr_o
);
    logic [PTR_W-1:0] delay_q;
    logic [PTR_W-1:0] rd_q;
    logic [PTR_W-1:0] even_delay;
    logic [PTR_W-1:0] next_delay;
    logic [PTR_W-1:0] next_rd;
    rel_e             rel;

    slewdly_target #(
        .PTR_W(PTR_W),
        .HI_W (HI_W)
    ) u_target (
        .want_hi   (want_hi_i),
        .cur_delay (delay_q),
        .even_delay(even_delay),
        .rel       (rel)
    );

    slewdly_step #(
        .PTR_W  (PTR_W),
        .UP_STEP(UP_STEP),
        .DN_STEP(DN_STEP)
    ) u_step (
        .even_delay(even_delay),
        .rel       (rel),
        .next_delay(next_delay)
    );

    slewdly_rdptr #(
        .PTR_W(PTR_W)
    ) u_rdptr (
        .wr_ptr(wr_ptr_i),
        .delay (next_delay),
        .rd_ptr(next_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            delay_q <= '0;
            rd_q    <= '0;
        end else if (frame_i) begin
            delay_q <= next_delay;
            rd_q    <= next_rd;
        end
    end

    assign delay_o  = delay_q;
    assign rd_ptr_o = rd_q;
endmodule

// File: rtl/slewdly_chk.sv
module slewdly_chk #(
    parameter int PTR_W   = 16,
    parameter int HI_W    = 8,
    parameter int UP_STEP = 4,
    parameter int DN_STEP = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_i,
    input logic [HI_W-1:0]  want_hi_i,
    input logic [PTR_W-1:0] wr_ptr_i,
    input logic [PTR_W-1:0] delay_o,
    input logic [PTR_W-1:0] rd_ptr_o
);
    localparam logic [PTR_W-1:0] UP_V = PTR_W'(UP_STEP);
    localparam logic [PTR_W-1:0] DN_V = PTR_W'(DN_STEP);

    logic [PTR_W-1:0] tgt;
    assign tgt = PTR_W'(want_hi_i) << (PTR_W - HI_W);

    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (delay_o == '0 && rd_ptr_o == '0));

    // R2
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> ($stable(delay_o) && $stable(rd_ptr_o)));

    // R4
    a_r4_equal_hold: assert property (@(posedge clk) disable iff (rst)
        (frame_i && delay_o == tgt) |=> $stable(delay_o));

    // R5
    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (frame_i && delay_o > tgt) |=> (delay_o == $past(delay_o) - DN_V));

    // R6
    a_r6_step_up: assert property (@(posedge clk) disable iff (rst)
        (frame_i && delay_o < tgt) |=> (delay_o == $past(delay_o) + UP_V));

    // R7
    a_r7_rd_follows: assert property (@(posedge clk) disable iff (rst)
        frame_i |=> (rd_ptr_o == $past(wr_ptr_i) - delay_o));

    // R8
    a_r8_even: assert property (@(posedge clk) disable iff (rst)
        delay_o[0] == 1'b0);
endmodule

bind slew_delay_ptr slewdly_chk #(
    .PTR_W  (PTR_W),
    .HI_W   (HI_W),
    .UP_STEP(UP_STEP),
    .DN_STEP(DN_STEP)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_i  (frame_i),
    .want_hi_i(want_hi_i),
    .wr_ptr_i (wr_ptr_i),
    .delay_o  (delay_o),
    .rd_ptr_o (rd_ptr_o)
);

// File: tb/slew_delay_ptr_test.sv
module slew_delay_ptr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame = 1'b0;
    logic [7:0]  want = 8'h00;
    logic [15:0] wr = 16'h0000;
    logic [15:0] delay;
    logic [15:0] rd;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    slew_delay_ptr uut (
        .clk      (clk),
        .rst      (rst),
        .frame_i  (frame),
        .want_hi_i(want),
        .wr_ptr_i (wr),
        .delay_o  (delay),
        .rd_ptr_o (rd)
    );

    // {want, wr, expected delay, expected read pointer}, starting from delay 0
    localparam logic [55:0] VEC [11] = '{
        {8'h00, 16'h1234, 16'h0000, 16'h1234},
        {8'h01, 16'h0002, 16'h0004, 16'hFFFE},
        {8'h01, 16'h0010, 16'h0008, 16'h0008},
        {8'h00, 16'h0020, 16'h0006, 16'h001A},
        {8'h00, 16'h0021, 16'h0004, 16'h001D},
        {8'h80, 16'hFFFF, 16'h0008, 16'hFFF7},
        {8'h00, 16'h0000, 16'h0006, 16'hFFFA},
        {8'h00, 16'h0100, 16'h0004, 16'h00FC},
        {8'h00, 16'h0005, 16'h0002, 16'h0003},
        {8'h00, 16'h7777, 16'h0000, 16'h7777},
        {8'h00, 16'hABCD, 16'h0000, 16'hABCD}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one strobe; outputs are sampled at the following falling edge
    task automatic do_frame(input logic [7:0] w, input logic [15:0] p);
        @(negedge clk);
        want  = w;
        wr    = p;
        frame = 1'b1;
        @(negedge clk);
        frame = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int odd_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset delay", delay, 16'h0000);
        check("R1 reset rdptr", rd, 16'h0000);

        // table walk: R3 R4 R5 R6 R7 under mixed patterns
        for (int i = 0; i < 11; i++) begin
            do_frame(VEC[i][55:48], VEC[i][47:32]);
            check($sformatf("R4/R5/R6 vec%0d delay", i), delay, VEC[i][31:16]);
            check($sformatf("R7 vec%0d rdptr", i), rd, VEC[i][15:0]);
        end

        // R2: inputs move without a strobe
        @(negedge clk);
        want = 8'h40;
        wr   = 16'h5555;
        repeat (5) @(negedge clk);
        want = 8'hFF;
        wr   = 16'h0001;
        repeat (3) @(negedge clk);
        check("R2 idle delay", delay, 16'h0000);
        check("R2 idle rdptr", rd, 16'hABCD);

        // R6 climb to 0x0100 in 64 strobes, then R4 hold
        odd_seen = 0;
        for (int k = 0; k < 64; k++) begin
            do_frame(8'h01, 16'(k));
            if (delay[0]) odd_seen++;
        end
        check("R6 climb delay", delay, 16'h0100);
        check("R7 climb rdptr", rd, 16'(63) - 16'h0100);
        do_frame(8'h01, 16'h0200);
        check("R4 hold at target", delay, 16'h0100);
        check("R7 hold rdptr", rd, 16'h0100);

        // R8 overshoot and settle
        do_frame(8'h00, 16'h0000);
        check("R5 one step down", delay, 16'h00FE);
        do_frame(8'h01, 16'h0000);
        check("R8 overshoot", delay, 16'h0102);
        do_frame(8'h01, 16'h0000);
        check("R8 settle", delay, 16'h0100);
        do_frame(8'h01, 16'h0000);
        check("R8 stays", delay, 16'h0100);

        // R3 unsigned compare: climb to 0xFF00
        n = 0;
        while (delay != 16'hFF00 && n < 20000) begin
            do_frame(8'hFF, 16'h0010);
            if (delay[0]) odd_seen++;
            n++;
        end
        check("R3 top frames", 16'(n), 16'(16256));
        check("R3 top delay", delay, 16'hFF00);
        check("R7 wrap rdptr", rd, 16'h0110);
        check("R8 even throughout", 16'(odd_seen), 16'h0000);
        do_frame(8'hFF, 16'h0010);
        check("R4 hold top", delay, 16'hFF00);
        do_frame(8'h7F, 16'h0000);
        check("R3 high above low target", delay, 16'hFEFE);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rerun delay", delay, 16'h0000);
        check("R1 rerun rdptr", rd, 16'h0000);
        do_frame(8'h00, 16'h4321);
        check("R7 start equals write", rd, 16'h4321);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule